// File: doc/BRIEF.md
# Thermal Fan Duty Controller

This block drives a cooling fan with a pulse-width modulated output. The pulse period is a fixed build-time constant, reported on an output. The high time comes from a width value that software writes through a small register port. Alongside that software path, the block watches a stream of raw 16-bit temperature codes from an external sensor front end. It maps each code onto one of several duty levels through a set of parameterised thresholds, and it raises the fan duty on its own when the temperature climbs into a higher level.

A hardware-initiated increase always runs the same sequence. First a temperature-increase event pulses. The new width is then applied at the next period boundary. A settling interval follows so the fan speed can stabilise, and only then does the duty-changed event pulse. A software width write, or a hardware step down once the temperature has cooled, needs no settling: it pulses the duty-changed event in the cycle the new width becomes active. The settling interval is counted in clock cycles, derived from a clock-frequency parameter and a millisecond parameter (5000 ms by default).

A temperature code relates to degrees as degrees = code × 501.3743 / 65536 − 273.6777. The default thresholds correspond to about 40, 50 and 60 degrees. The whole output side stays quiet until software sets the run bit of the control register.

Top module: `thermal_fan_pwm`

## Requirements
- R1: After reset `pwm_out` is low, `irq_evt` is 0, `duty_width` is 0 and `pwm_period` equals the PERIOD parameter (100 by default).
- R2: While control bit 0 is 0 (register select 1, written via `cfg_wr_data[0]`), `pwm_out` stays low, temperature samples are ignored, no event pulses, and a written width becomes active on `duty_width` within two cycles.
- R3: While running, `pwm_out` is high for min(width, PERIOD) cycles of every PERIOD-cycle frame, starting with the first cycle of the frame; a width of 0 gives a constantly low output.
- R4: A newly written width becomes active only at a frame boundary, so the first sample that shows the new `duty_width` is the first cycle of a frame and no shortened pulse appears.
- R5: A software width write (register select 0) pulses `irq_evt[0]` (duty changed) for one cycle in the same cycle the new width appears on `duty_width`, and `irq_evt[2]` stays 0.
- R6: A temperature sample that lands in a higher level pulses `irq_evt[2]` (temperature increase) for one cycle, two cycles after the sample is presented. The level's duty width becomes active at the next frame boundary after that.
- R7: After a hardware-raised width becomes active, `irq_evt[0]` pulses exactly SETTLE cycles later (SETTLE = CLK_HZ/1000 × SETTLE_MS), and not before.
- R8: The level falls only when code + HYST is below the threshold of the current level. Such a fall applies the lower duty at the next frame boundary and pulses `irq_evt[0]` with no `irq_evt[2]`. A code between the two limits changes nothing.
- R9: If a software width write arrives in the same cycle that a hardware increase is being queued, the software value is discarded and the hardware width is applied.
- R10: The level is the number of thresholds at or below the code, so one sample may jump several levels. Levels 0 to 3 map to widths 25, 50, 75 and 100 by default, and `irq_evt[1]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 1 | 0 = width register, 1 = control register (bit 0 = run) |
| cfg_wr_data | input | WW | Write data |
| temp_valid | input | 1 | Temperature sample strobe |
| temp_code | input | CODE_W | Raw unsigned temperature code |
| pwm_out | output | 1 | Fan drive output |
| duty_width | output | WW | Currently active high time in cycles |
| pwm_period | output | WW | Fixed frame length in cycles |
| irq_evt | output | 3 | Event pulses: bit 0 duty changed, bit 1 always 0, bit 2 temperature increase |

## Verification
The software width write and a hardware increase can meet in one cycle, because the thermal level decision is registered one cycle before it is queued. The bench presents a temperature sample that jumps two levels and, on the very next cycle, writes a different software width. This puts both requests in the same queueing cycle. The run is judged correct when the temperature-increase pulse appears, the hardware width of that level is applied, duty-changed follows only after the full settling count, and the software value never shows on `duty_width` over the next two frames.

// File: rtl/fanpwm_pkg.sv
package fanpwm_pkg;
  localparam int EVT_W    = 3;
  localparam int EVT_CHG  = 0;
  localparam int EVT_RISE = 2;

  typedef enum logic {
    SRC_DIRECT  = 1'b0,
    SRC_THERMAL = 1'b1
  } chg_src_e;

  typedef enum logic {
    SEL_WIDTH = 1'b0,
    SEL_CTRL  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/fanpwm_thermal.sv
module fanpwm_thermal #(
  parameter int N_TH    = 3,
  parameter int CODE_W  = 16,
  parameter int WW      = 8,
  parameter logic [N_TH*CODE_W-1:0] TH_CODES = {16'd43616, 16'd42309, 16'd41002},
  parameter int TH_HYST = 1307,
  parameter logic [(N_TH+1)*WW-1:0] DUTY_W = {8'd100, 8'd75, 8'd50, 8'd25}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] smp_code,
  output logic              rise_o,
  output logic              fall_o,
  output logic [WW-1:0]     tgt_w_o
);
  localparam int LVL_W = $clog2(N_TH + 1);
  localparam logic [CODE_W:0] HYST_X = (CODE_W+1)'(TH_HYST);

  logic [N_TH-1:0]  ge_up, ge_dn;
  logic [LVL_W-1:0] up_cnt, dn_cnt;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             rise_q, rise_d, fall_q, fall_d;
  logic [WW-1:0]    tgt_q, tgt_d;

  function automatic logic [WW-1:0] duty_of(input logic [LVL_W-1:0] l);
    duty_of = '0;
    for (int i = 0; i <= N_TH; i++)
      if (l == LVL_W'(i)) duty_of = DUTY_W[i*WW +: WW];
  endfunction

  for (genvar g = 0; g < N_TH; g++) begin : g_cmp
    assign ge_up[g] = smp_code >= TH_CODES[g*CODE_W +: CODE_W];
    assign ge_dn[g] = ({1'b0, smp_code} + HYST_X) >= {1'b0, TH_CODES[g*CODE_W +: CODE_W]};
  end

  always_comb begin
    up_cnt = '0;
    dn_cnt = '0;
    for (int i = 0; i < N_TH; i++) begin
      up_cnt = up_cnt + LVL_W'(ge_up[i]);
      dn_cnt = dn_cnt + LVL_W'(ge_dn[i]);
    end
  end

  always_comb begin
    lvl_d  = lvl_q;
    rise_d = 1'b0;
    fall_d = 1'b0;
    tgt_d  = tgt_q;
    if (!run) begin
      lvl_d = '0;
    end else if (smp_valid) begin
      if (up_cnt > lvl_q) begin
        lvl_d  = up_cnt;
        rise_d = 1'b1;
        tgt_d  = duty_of(up_cnt);
      end else if (dn_cnt < lvl_q) begin
        lvl_d  = dn_cnt;
        fall_d = 1'b1;
        tgt_d  = duty_of(dn_cnt);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      tgt_q  <= '0;
    end else begin
      lvl_q  <= lvl_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
      tgt_q  <= tgt_d;
    end
  end

  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
  assign tgt_w_o = tgt_q;
endmodule

// File: rtl/fanpwm_gen.sv
module fanpwm_gen #(
  parameter int PERIOD = 100,
  parameter int WW     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [WW-1:0]    act_w,
  output logic             boundary_o,
  output logic [$clog2(PERIOD)-1:0] cnt_o,
  output logic             pwm_o
);
  localparam int CNT_W = $clog2(PERIOD);
  localparam int CMP_W = (CNT_W > WW) ? CNT_W : WW;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)         cnt_d = '0;
    else if (at_last) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign boundary_o = !run || at_last;
  assign cnt_o      = cnt_q;
  assign pwm_o      = run && (CMP_W'(cnt_q) < CMP_W'(act_w));
endmodule

// File: rtl/fanpwm_seq.sv
module fanpwm_seq
  import fanpwm_pkg::*;
#(
  parameter int          WW         = 8,
  parameter int unsigned SETTLE_CYC = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             sw_wr,
  input  logic [WW-1:0]    sw_w,
  input  logic             hw_rise,
  input  logic             hw_fall,
  input  logic [WW-1:0]    hw_w,
  input  logic             boundary,
  output logic [WW-1:0]    act_w_o,
  output logic [EVT_W-1:0] evt_o
);
  localparam int ST_W = $clog2(SETTLE_CYC + 1);
  localparam logic [ST_W-1:0] ST_LAST = ST_W'(SETTLE_CYC - 1);

  logic [WW-1:0]   pend_w_q, pend_w_d, act_q, act_d;
  logic            pend_v_q, pend_v_d;
  chg_src_e        pend_src_q, pend_src_d;
  logic            busy_q, busy_d;
  logic [ST_W-1:0] st_q, st_d;
  logic            chg_q, chg_d, rise_q, rise_d;
  logic            apply;

  assign apply = boundary && pend_v_q;

  always_comb begin
    pend_w_d   = pend_w_q;
    pend_v_d   = pend_v_q;
    pend_src_d = pend_src_q;
    act_d      = act_q;
    busy_d     = busy_q;
    st_d       = st_q;
    chg_d      = 1'b0;
    rise_d     = hw_rise && run;

    if (busy_q) begin
      if (st_q == ST_LAST) begin
        busy_d = 1'b0;
        chg_d  = 1'b1;
      end else begin
        st_d = st_q + 1'b1;
      end
    end

    if (apply) begin
      act_d    = pend_w_q;
      pend_v_d = 1'b0;
      if (pend_src_q == SRC_THERMAL) begin
        busy_d = 1'b1;
        st_d   = '0;
      end else begin
        chg_d = chg_d || run;
      end
    end

    if (!run) begin
      busy_d = 1'b0;
      chg_d  = 1'b0;
    end

    if (hw_rise && run) begin
      pend_w_d   = hw_w;
      pend_v_d   = 1'b1;
      pend_src_d = SRC_THERMAL;
    end else if (sw_wr) begin
      pend_w_d   = sw_w;
      pend_v_d   = 1'b1;
      pend_src_d = SRC_DIRECT;
    end else if (hw_fall && run) begin
      pend_w_d   = hw_w;
      pend_v_d   = 1'b1;
      pend_src_d = SRC_DIRECT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_w_q   <= '0;
      pend_v_q   <= 1'b0;
      pend_src_q <= SRC_DIRECT;
      act_q      <= '0;
      busy_q     <= 1'b0;
      st_q       <= '0;
      chg_q      <= 1'b0;
      rise_q     <= 1'b0;
    end else begin
      pend_w_q   <= pend_w_d;
      pend_v_q   <= pend_v_d;
      pend_src_q <= pend_src_d;
      act_q      <= act_d;
      busy_q     <= busy_d;
      st_q       <= st_d;
      chg_q      <= chg_d;
      rise_q     <= rise_d;
    end
  end

  assign act_w_o         = act_q;
  assign evt_o[EVT_CHG]  = chg_q;
  assign evt_o[1]        = 1'b0;
  assign evt_o[EVT_RISE] = rise_q;
endmodule

// File: rtl/thermal_fan_pwm.sv
module thermal_fan_pwm
  import fanpwm_pkg::*;
#(
  parameter int N_TH    = 3,
  parameter int CODE_W  = 16,
  parameter int WW      = 8,
  parameter int PERIOD  = 100,
  parameter logic [N_TH*CODE_W-1:0] TH_CODES = {16'd43616, 16'd42309, 16'd41002},
  parameter int TH_HYST = 1307,
  parameter logic [(N_TH+1)*WW-1:0] DUTY_W = {8'd100, 8'd75, 8'd50, 8'd25},
  parameter longint unsigned CLK_HZ    = 250_000_000,
  parameter longint unsigned SETTLE_MS = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic              cfg_wr_sel,
  input  logic [WW-1:0]     cfg_wr_data,
  input  logic              temp_valid,
  input  logic [CODE_W-1:0] temp_code,
  output logic              pwm_out,
  output logic [WW-1:0]     duty_width,
  output logic [WW-1:0]     pwm_period,
  output logic [2:0]        irq_evt
);
  localparam longint unsigned SETTLE_L = (CLK_HZ / 1000) * SETTLE_MS;
  localparam int unsigned SETTLE_CYC = (SETTLE_L == 0) ? 1 : 32'(SETTLE_L);
  localparam int CNT_W = $clog2(PERIOD);

  logic        rst_m, rst_s;
  logic        run_q, run_d;
  logic        sw_wr;
  logic        hw_rise, hw_fall;
  logic [WW-1:0]    hw_w;
  logic             boundary;
  logic [CNT_W-1:0] cnt_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  assign sw_wr = cfg_wr_en && (cfg_wr_sel == SEL_WIDTH);

  always_comb begin
    run_d = run_q;
    if (cfg_wr_en && (cfg_wr_sel == SEL_CTRL)) run_d = cfg_wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  fanpwm_thermal #(
    .N_TH(N_TH), .CODE_W(CODE_W), .WW(WW),
    .TH_CODES(TH_CODES), .TH_HYST(TH_HYST), .DUTY_W(DUTY_W)
  ) thermal_i (
    .clk(clk), .rst_n(rst_s), .run(run_q),
    .smp_valid(temp_valid), .smp_code(temp_code),
    .rise_o(hw_rise), .fall_o(hw_fall), .tgt_w_o(hw_w)
  );

  fanpwm_seq #(.WW(WW), .SETTLE_CYC(SETTLE_CYC)) seq_i (
    .clk(clk), .rst_n(rst_s), .run(run_q),
    .sw_wr(sw_wr), .sw_w(cfg_wr_data),
    .hw_rise(hw_rise), .hw_fall(hw_fall), .hw_w(hw_w),
    .boundary(boundary), .act_w_o(duty_width), .evt_o(irq_evt)
  );

  fanpwm_gen #(.PERIOD(PERIOD), .WW(WW)) gen_i (
    .clk(clk), .rst_n(rst_s), .run(run_q), .act_w(duty_width),
    .boundary_o(boundary), .cnt_o(cnt_w), .pwm_o(pwm_out)
  );

  assign pwm_period = WW'(PERIOD);
endmodule

// File: rtl/thermal_fan_pwm_chk.sv
module thermal_fan_pwm_chk #(
  parameter int PERIOD = 100,
  parameter int WW     = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      run,
  input logic [$clog2(PERIOD)-1:0] cnt,
  input logic [WW-1:0]             act_w,
  input logic                      pwm,
  input logic [2:0]                evt
);
  AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!pwm && evt == 3'b000)); // R2

  AST_WIDTH_AT_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_w != $past(act_w)) |-> cnt == '0); // R4

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt[2] |=> !evt[2]); // R6

  AST_CHG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[0] && run) |=> !evt[0]); // R5

  AST_RISE_NOT_WITH_CHG: assert property (@(posedge clk) disable iff (!rst_n)
    evt[2] |-> !evt[0]); // R7
endmodule

bind thermal_fan_pwm thermal_fan_pwm_chk #(.PERIOD(PERIOD), .WW(WW)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run_q), .cnt(cnt_w),
  .act_w(duty_width), .pwm(pwm_out), .evt(irq_evt)
);

// File: tb/thermal_fan_pwm_tb_top.sv
module thermal_fan_pwm_tb_top;
  localparam int PERIOD = 100;
  localparam int SETTLE = 30;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic       cfg_wr_sel = 1'b0;
  logic [7:0] cfg_wr_data = '0;
  logic       temp_valid = 1'b0;
  logic [15:0] temp_code = '0;
  logic       pwm_out;
  logic [7:0] duty_width, pwm_period;
  logic [2:0] irq_evt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  thermal_fan_pwm #(.CLK_HZ(1000), .SETTLE_MS(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .temp_valid(temp_valid), .temp_code(temp_code),
    .pwm_out(pwm_out), .duty_width(duty_width), .pwm_period(pwm_period),
    .irq_evt(irq_evt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input bit sel, input logic [7:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic sample_temp(input logic [15:0] c);
    @(negedge clk);
    temp_valid = 1'b1; temp_code = c;
    @(negedge clk);
    temp_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(pwm_out == 1'b0, "R1 pwm", int'(pwm_out), 0);
    chk(irq_evt == 3'b000, "R1 evt", int'(irq_evt), 0);
    chk(duty_width == 8'd0, "R1 width", int'(duty_width), 0);
    chk(pwm_period == 8'(PERIOD), "R1 period", int'(pwm_period), PERIOD);
  endtask

  task automatic t_held();
    int hi = 0;
    int ev = 0;
    reg_write(1'b0, 8'd40);
    sample_temp(16'd43700);
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      hi += int'(pwm_out);
      ev += int'(irq_evt != 3'b000);
    end
    chk(hi == 0, "R2 pwm low while held", hi, 0);
    chk(ev == 0, "R2 no events while held", ev, 0);
    chk(duty_width == 8'd40, "R2 width accepted while held", int'(duty_width), 40);
  endtask

  task automatic t_run_duty();
    int hi = 0;
    reg_write(1'b1, 8'd1);
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      hi += int'(pwm_out);
    end
    chk(hi == 40, "R3 duty after run", hi, 40);
  endtask

  task automatic t_sw(input logic [7:0] w, input int exp_hi);
    logic [7:0] old_w = duty_width;
    bit found = 1'b0;
    int early_evt = 0;
    int hi = 0;
    reg_write(1'b0, w);
    for (int i = 0; i < PERIOD + 3; i++) begin
      if (duty_width != old_w) begin found = 1'b1; break; end
      early_evt += int'(irq_evt != 3'b000);
      @(negedge clk);
    end
    chk(found && duty_width == w, "R4 width applied", int'(duty_width), int'(w));
    chk(early_evt == 0, "R4 no event before boundary", early_evt, 0);
    chk(irq_evt == 3'b001, "R5 change event with width", int'(irq_evt), 1);
    chk(pwm_out == (w != 0), "R4 full pulse at frame start", int'(pwm_out), int'(w != 0));
    hi = int'(pwm_out);
    for (int i = 1; i < PERIOD; i++) begin
      @(negedge clk);
      hi += int'(pwm_out);
    end
    chk(hi == exp_hi, "R3 duty count", hi, exp_hi);
  endtask

  task automatic t_hw(input logic [15:0] c, input logic [7:0] exp_w,
                      input bit inject, input logic [7:0] sw_val, input string tag);
    logic [7:0] old_w = duty_width;
    bit found = 1'b0;
    int k = 0;
    int bad = 0;
    @(negedge clk);
    temp_valid = 1'b1; temp_code = c;
    @(negedge clk);
    temp_valid = 1'b0;
    chk(irq_evt[2] == 1'b0, "R6 rise not yet", int'(irq_evt[2]), 0);
    if (inject) begin
      cfg_wr_en = 1'b1; cfg_wr_sel = 1'b0; cfg_wr_data = sw_val;
    end
    @(negedge clk);
    cfg_wr_en = 1'b0;
    chk(irq_evt[2] == 1'b1, "R6 rise event", int'(irq_evt[2]), 1);
    for (int i = 0; i < PERIOD + 3; i++) begin
      @(negedge clk);
      if (duty_width != old_w) begin found = 1'b1; break; end
    end
    chk(found && duty_width == exp_w, tag, int'(duty_width), int'(exp_w));
    chk(irq_evt[0] == 1'b0, "R7 no change event at apply", int'(irq_evt[0]), 0);
    for (int i = 0; i < SETTLE + 5; i++) begin
      @(negedge clk);
      k++;
      if (irq_evt[0]) break;
    end
    chk(k == SETTLE, "R7 settle delay", k, SETTLE);
    if (inject) begin
      for (int i = 0; i < 2 * PERIOD; i++) begin
        @(negedge clk);
        bad += int'(duty_width != exp_w);
      end
      chk(bad == 0, "R9 software value discarded", bad, 0);
    end
  endtask

  task automatic t_hyst_hold();
    logic [7:0] old_w = duty_width;
    int ev = 0;
    int chg = 0;
    sample_temp(16'd40000);
    for (int i = 0; i < 2 * PERIOD; i++) begin
      @(negedge clk);
      ev += int'(irq_evt != 3'b000);
      chg += int'(duty_width != old_w);
    end
    chk(ev == 0 && chg == 0, "R8 inside hysteresis band", ev + chg, 0);
  endtask

  task automatic t_fall();
    bit found = 1'b0;
    sample_temp(16'd39000);
    for (int i = 0; i < PERIOD + 3; i++) begin
      @(negedge clk);
      if (duty_width != 8'd50) begin found = 1'b1; break; end
    end
    chk(found && duty_width == 8'd25, "R8 falls to level 0", int'(duty_width), 25);
    chk(irq_evt == 3'b001, "R8 direct event on fall", int'(irq_evt), 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_held();
    t_run_duty();
    t_sw(8'd30, 30);
    t_sw(8'd0, 0);
    t_sw(8'd150, PERIOD);
    t_hw(16'd41100, 8'd50, 1'b0, 8'd0, "R6 level 1 width");
    t_hyst_hold();
    t_fall();
    t_hw(16'd42400, 8'd75, 1'b1, 8'd10, "R10 jump to level 2 width");
    t_hw(16'd43700, 8'd100, 1'b0, 8'd0, "R10 level 3 width");
    chk(irq_evt[1] == 1'b0, "R10 bit1 zero", int'(irq_evt[1]), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule